// File: doc/BRIEF.md
# Console Reset and Boot Watchdog Sequencer

This block supervises processor reset for a console-style system. A debounced reset button does not reset the processor at once. The block first raises a maskable warning interrupt. It then sends a reset command to the cartridge security chip and waits for that chip to acknowledge. The chip supplies the grace period during which software can save its state. After the acknowledge, the block waits for the button to be released and only then pulses the non-maskable reset. On that same pulse it makes the boot ROM visible again.

Software talks to the block through one-cycle request strobes. These are decoded from a shared mailbox byte: bit 0x08 means boot finished and bit 0x10 means lock the boot ROM. Each request is answered with a one-cycle clear strobe so the mailbox bit can be dropped. The button only works once boot has been reported finished, and it must be re-enabled after every soft reset. A boot watchdog halts the processor for good if the report never arrives. All times are parameters counted in clock cycles.

Top module: `rst_seq`

## Requirements
- R1: After power-on reset the block is in the boot phase. Warning interrupt, non-maskable reset, halt and the security command valid are all 0, and the boot ROM is visible (rom_vis_o = 1).
- R2: During the boot phase, before a boot-finished request, a pressed button has no effect: pre_irq_o stays 0.
- R3: A boot-finished request (cmd_boot_done_i) enables the button. It is answered by clr_boot_done_o high for exactly the one cycle after the request.
- R4: A button press in the run phase raises pre_irq_o in the next cycle. In that same cycle sec_cmd_valid_o is high for one cycle with sec_cmd_o = 2'b11. nmi_o stays 0.
- R5: The block then waits for an acknowledge. This is sec_ack_valid_i high with sec_ack_bit_i = 0. A valid with bit 1 is ignored, and pre_irq_o stays high while waiting.
- R6: After the acknowledge the block waits without limit while the button is held, and nmi_o stays 0.
- R7: One cycle after release, nmi_o is high for exactly NMI_CYCLES cycles. In the first of these cycles pre_irq_o is 0 and the boot ROM is visible again.
- R8: After the NMI pulse the block is back in the boot phase. The button is ignored again until a new boot-finished request.
- R9: If no boot-finished request arrives within WD_CYCLES cycles of entering the boot phase, halt_o and nmi_o rise and stay high until power-on reset. Button presses are then ignored.
- R10: A ROM-lock request (cmd_rom_lock_i) drives rom_vis_o to 0 in the next cycle and forces rom_rdata_o to all zeros while locked. It is answered by clr_rom_lock_o for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| btn_i | input | 1 | Debounced reset button, 1 = pressed |
| cmd_boot_done_i | input | 1 | Boot-finished request strobe |
| cmd_rom_lock_i | input | 1 | Boot-ROM lock request strobe |
| clr_boot_done_o | output | 1 | Clears the boot-finished mailbox bit |
| clr_rom_lock_o | output | 1 | Clears the ROM-lock mailbox bit |
| sec_cmd_valid_o | output | 1 | Command to security chip is valid |
| sec_cmd_o | output | 2 | Command code (2'b11 = reset) |
| sec_ack_valid_i | input | 1 | Acknowledge bit from security chip is valid |
| sec_ack_bit_i | input | 1 | Acknowledge bit value, 0 = accepted |
| pre_irq_o | output | 1 | Maskable warning interrupt |
| nmi_o | output | 1 | Non-maskable reset to processor |
| halt_o | output | 1 | Watchdog halt, sticky |
| rom_vis_o | output | 1 | Boot ROM visible to the processor |
| rom_rdata_i | input | ROM_DW | Raw boot-ROM read data |
| rom_rdata_o | output | ROM_DW | Read data gated by the lock |

## Verification
Every output comes from a register fed by the inputs sampled at one edge, so each response to a stimulus is due exactly one cycle later. The exceptions are the NMI pulse, whose last cycle falls NMI_CYCLES after release, and the watchdog halt, which falls WD_CYCLES cycles after the block re-enters the boot phase. The gated read data is combinational and so follows the lock register in the same cycle. The driver changes inputs on the falling edge and queues each expected value tagged with the absolute cycle in which it must hold. The monitor compares those entries just after that rising edge, so a result a cycle early or late is caught.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;
  typedef enum logic [2:0] {
    ST_BOOT, ST_RUN, ST_WARN, ST_ACK, ST_REL, ST_NMI, ST_HALT
  } rs_state_e;
  localparam logic [1:0] SEC_RESET_CMD = 2'b11;
endpackage

// File: rtl/rs_seq_timer.sv
module rs_seq_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/rs_seq_fsm.sv
module rs_seq_fsm
  import rs_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      btn_i,
  input  logic      boot_done_req_i,
  input  logic      ack_ok_i,
  input  logic      wd_expired_i,
  input  logic      nmi_done_i,
  output rs_state_e state_o
);
  rs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_BOOT: if (boot_done_req_i)   st_d = ST_RUN;
               else if (wd_expired_i) st_d = ST_HALT;
      ST_RUN:  if (btn_i)      st_d = ST_WARN;
      ST_WARN:                 st_d = ST_ACK;
      ST_ACK:  if (ack_ok_i)   st_d = ST_REL;
      ST_REL:  if (!btn_i)     st_d = ST_NMI;
      ST_NMI:  if (nmi_done_i) st_d = ST_BOOT;
      ST_HALT:                 st_d = ST_HALT;
      default:                 st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_BOOT;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/rs_seq_rom_gate.sv
module rs_seq_rom_gate #(
  parameter int unsigned ROM_DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_req_i,
  input  logic              unlock_i,
  input  logic              done_req_i,
  input  logic [ROM_DW-1:0] rom_rdata_i,
  output logic              rom_vis_o,
  output logic [ROM_DW-1:0] rom_rdata_o,
  output logic              clr_done_o,
  output logic              clr_lock_o
);
  logic locked_q, clr_done_q, clr_lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q   <= 1'b0;
      clr_done_q <= 1'b0;
      clr_lock_q <= 1'b0;
    end else begin
      // reset path wins over a coincident lock request
      if (unlock_i)        locked_q <= 1'b0;
      else if (lock_req_i) locked_q <= 1'b1;
      clr_done_q <= done_req_i;
      clr_lock_q <= lock_req_i;
    end
  end

  assign rom_vis_o   = !locked_q;
  assign rom_rdata_o = locked_q ? '0 : rom_rdata_i;
  assign clr_done_o  = clr_done_q;
  assign clr_lock_o  = clr_lock_q;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rs_seq_pkg::*;
#(
  parameter int unsigned WD_CYCLES  = 250_000_000,
  parameter int unsigned NMI_CYCLES = 16,
  parameter int unsigned ROM_DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              btn_i,
  input  logic              cmd_boot_done_i,
  input  logic              cmd_rom_lock_i,
  output logic              clr_boot_done_o,
  output logic              clr_rom_lock_o,
  output logic              sec_cmd_valid_o,
  output logic [1:0]        sec_cmd_o,
  input  logic              sec_ack_valid_i,
  input  logic              sec_ack_bit_i,
  output logic              pre_irq_o,
  output logic              nmi_o,
  output logic              halt_o,
  output logic              rom_vis_o,
  input  logic [ROM_DW-1:0] rom_rdata_i,
  output logic [ROM_DW-1:0] rom_rdata_o
);
  rs_state_e state;
  logic wd_expired, nmi_done, ack_ok, unlock;

  assign ack_ok = sec_ack_valid_i && !sec_ack_bit_i;
  assign unlock = (state == ST_REL) && !btn_i;

  rs_seq_timer #(.LIMIT(WD_CYCLES)) u_wd (
    .clk_i, .rst_ni, .en_i(state == ST_BOOT), .done_o(wd_expired)
  );

  rs_seq_timer #(.LIMIT(NMI_CYCLES)) u_nmi_len (
    .clk_i, .rst_ni, .en_i(state == ST_NMI), .done_o(nmi_done)
  );

  rs_seq_fsm u_fsm (
    .clk_i, .rst_ni, .btn_i,
    .boot_done_req_i(cmd_boot_done_i),
    .ack_ok_i(ack_ok),
    .wd_expired_i(wd_expired),
    .nmi_done_i(nmi_done),
    .state_o(state)
  );

  rs_seq_rom_gate #(.ROM_DW(ROM_DW)) u_rom (
    .clk_i, .rst_ni,
    .lock_req_i(cmd_rom_lock_i),
    .unlock_i(unlock),
    .done_req_i(cmd_boot_done_i),
    .rom_rdata_i,
    .rom_vis_o,
    .rom_rdata_o,
    .clr_done_o(clr_boot_done_o),
    .clr_lock_o(clr_rom_lock_o)
  );

  assign pre_irq_o       = (state == ST_WARN) || (state == ST_ACK) || (state == ST_REL);
  assign sec_cmd_valid_o = (state == ST_WARN);
  assign sec_cmd_o       = sec_cmd_valid_o ? SEC_RESET_CMD : 2'b00;
  assign nmi_o           = (state == ST_NMI) || (state == ST_HALT);
  assign halt_o          = (state == ST_HALT);
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
  parameter int unsigned ROM_DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              btn_i,
  input logic              cmd_boot_done_i,
  input logic              clr_boot_done_o,
  input logic              sec_cmd_valid_o,
  input logic [1:0]        sec_cmd_o,
  input logic              pre_irq_o,
  input logic              nmi_o,
  input logic              halt_o,
  input logic              rom_vis_o,
  input logic [ROM_DW-1:0] rom_rdata_o
);
  a_r3_clear_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_boot_done_o |-> $past(cmd_boot_done_i));

  a_r4_reset_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_cmd_valid_o |-> (sec_cmd_o == 2'b11) && pre_irq_o && !nmi_o);

  a_r6_no_nmi_while_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_irq_o && btn_i |=> !nmi_o);

  a_r7_nmi_unlocks_rom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) && !halt_o |-> rom_vis_o && !pre_irq_o);

  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && nmi_o && !pre_irq_o);

  a_r10_locked_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_vis_o |-> rom_rdata_o == '0);
endmodule

bind rst_seq rst_seq_chk #(.ROM_DW(ROM_DW)) u_chk (
  .clk_i, .rst_ni, .btn_i, .cmd_boot_done_i, .clr_boot_done_o,
  .sec_cmd_valid_o, .sec_cmd_o, .pre_irq_o, .nmi_o, .halt_o,
  .rom_vis_o, .rom_rdata_o
);

// File: tb/rst_seq_tb.sv
module rst_seq_tb;
  localparam int WD  = 40;
  localparam int NMI = 4;
  localparam int DW  = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic btn = 1'b0, done_req = 1'b0, lock_req = 1'b0;
  logic ack_v = 1'b0, ack_b = 1'b1;
  logic [DW-1:0] rd_in = '0;
  logic clr_done, clr_lock, cmd_v, pre_irq, nmi, halt, vis;
  logic [1:0] cmd;
  logic [DW-1:0] rd_out;

  always #10 clk = ~clk;

  rst_seq #(.WD_CYCLES(WD), .NMI_CYCLES(NMI), .ROM_DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .btn_i(btn),
    .cmd_boot_done_i(done_req), .cmd_rom_lock_i(lock_req),
    .clr_boot_done_o(clr_done), .clr_rom_lock_o(clr_lock),
    .sec_cmd_valid_o(cmd_v), .sec_cmd_o(cmd),
    .sec_ack_valid_i(ack_v), .sec_ack_bit_i(ack_b),
    .pre_irq_o(pre_irq), .nmi_o(nmi), .halt_o(halt), .rom_vis_o(vis),
    .rom_rdata_i(rd_in), .rom_rdata_o(rd_out)
  );

  typedef struct { int cyc; int sel; int val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic int obs(int sel);
    case (sel)
      0: return int'(pre_irq);
      1: return int'(nmi);
      2: return int'(halt);
      3: return int'(vis);
      4: return int'(cmd_v);
      5: return int'(clr_done);
      6: return int'(clr_lock);
      7: return int'(rd_out);
      default: return int'(cmd);
    endcase
  endfunction

  task automatic exp_at(int d, int sel, int val, string req);
    exp_t e;
    e.cyc = cyc + d; e.sel = sel; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    cyc++;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        n_chk++;
        if (obs(q[i].sel) !== q[i].val) begin
          n_fail++;
          $display("FAIL %s cycle %0d signal %0d: actual %0d expected %0d",
                   q[i].req, cyc, q[i].sel, obs(q[i].sel), q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rd_in = 8'hA5;
    step(2);
    rst_ni = 1'b1;
    // R1 reset state
    exp_at(1, 0, 0, "R1"); exp_at(1, 1, 0, "R1"); exp_at(1, 2, 0, "R1");
    exp_at(1, 3, 1, "R1"); exp_at(1, 4, 0, "R1"); exp_at(1, 7, 8'hA5, "R1");
    step(1);
    // R2 button ignored before boot finished
    btn = 1'b1;
    for (int i = 1; i <= 3; i++) exp_at(i, 0, 0, "R2");
    step(3);
    btn = 1'b0;
    // R3 boot-finished request and its clear
    done_req = 1'b1;
    exp_at(1, 5, 1, "R3");
    step(1);
    done_req = 1'b0;
    exp_at(1, 5, 0, "R3");
    step(1);
    // R10 ROM lock
    lock_req = 1'b1;
    exp_at(1, 3, 0, "R10"); exp_at(1, 6, 1, "R10"); exp_at(1, 7, 0, "R10");
    step(1);
    lock_req = 1'b0;
    exp_at(1, 6, 0, "R10"); exp_at(1, 3, 0, "R10");
    step(1);
    // R4 press in run phase
    btn = 1'b1;
    exp_at(1, 0, 1, "R4"); exp_at(1, 4, 1, "R4"); exp_at(1, 8, 3, "R4");
    exp_at(1, 1, 0, "R4");
    step(1);
    exp_at(1, 4, 0, "R4"); exp_at(1, 0, 1, "R4");
    step(1);
    // R5 ack with bit 1 ignored, bit 0 accepted
    ack_v = 1'b1; ack_b = 1'b1;
    exp_at(1, 0, 1, "R5"); exp_at(1, 1, 0, "R5");
    step(1);
    ack_v = 1'b0;
    exp_at(1, 0, 1, "R5");
    step(1);
    ack_v = 1'b1; ack_b = 1'b0;
    exp_at(1, 1, 0, "R5");
    step(1);
    ack_v = 1'b0; ack_b = 1'b1;
    // R6 wait while held
    for (int i = 1; i <= 5; i++) begin
      exp_at(i, 1, 0, "R6"); exp_at(i, 0, 1, "R6");
    end
    step(5);
    // R7 release -> NMI pulse, ROM visible again
    btn = 1'b0;
    for (int i = 1; i <= NMI; i++) exp_at(i, 1, 1, "R7");
    exp_at(1, 3, 1, "R7"); exp_at(1, 0, 0, "R7"); exp_at(1, 7, 8'hA5, "R7");
    exp_at(NMI + 1, 1, 0, "R7");
    // R9 watchdog restarts on entering boot phase
    exp_at(NMI + WD, 2, 0, "R9");
    exp_at(NMI + WD + 1, 2, 1, "R9");
    exp_at(NMI + WD + 1, 1, 1, "R9");
    exp_at(NMI + WD + 16, 2, 1, "R9");
    exp_at(NMI + WD + 16, 1, 1, "R9");
    step(NMI + 2);
    // R8 button ignored again after soft reset
    btn = 1'b1;
    exp_at(1, 0, 0, "R8"); exp_at(2, 0, 0, "R8");
    step(2);
    btn = 1'b0;
    step(WD);
    // R9 button ignored while halted
    btn = 1'b1;
    exp_at(1, 0, 0, "R9"); exp_at(2, 0, 0, "R9");
    step(2);
    btn = 1'b0;
    step(20);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule